// File: doc/BRIEF.md
# Multi-Valued Address-Matching Data Selector

This block returns one radix-z digit chosen by an n-digit radix-z address, using priority-ranked multi-valued gates instead of a binary AND/OR decoder. A priority list supplied at the ports ranks the z digit values. Rank 0 is the weakest value (infimum) and rank z-1 is the strongest (supremum). Each stored entry holds an n-digit target address and a data digit.

For each entry, one digit-match operator per address digit sends out the infimum when its digit agrees with the target. Otherwise it sends out the supremum. An entry gate takes these outputs, plus the entry's data digit, and passes on the strongest input. An entry that misses therefore presents the supremum, and an entry that hits presents its data. A merge gate then combines all entries using the mirrored priority list. Under that list the supremum is the weakest value, so entries that miss drop out and the hit entry's data reaches the output.

A parameter selects a second form in which each match operator emits the data digit itself on a hit. That form needs n inputs per entry gate instead of n+1. Entries are written through a synchronous load port. The path from address to output is purely combinational.

Top module: `mvs_addr_selector`

## Requirements
- R1: After a synchronous active-high reset, no entry is loaded, and `sel_o` equals the supremum digit `order_i[RADIX-1]` for every address.
- R2: A load (`load_en_i`=1) with `load_idx_i` < NENT writes that entry's address and data at the clock edge. The write is visible from the next cycle, and a second load to the same index replaces the old contents. A load with `load_idx_i` >= NENT changes no entry.
- R3: When exactly one loaded entry matches every address digit, `sel_o` equals that entry's data digit.
- R4: An entry with even one mismatching digit has no effect on `sel_o`.
- R5: When no loaded entry matches, `sel_o` equals the supremum digit.
- R6: `order_i[k]` is the digit value holding rank k, for k = 0 (infimum) up to RADIX-1 (supremum). A change of the list changes `sel_o` in the same cycle.
- R7: When several loaded entries match, `sel_o` is the data digit with the lowest rank among them.
- R8: A matching entry whose data equals the supremum digit yields the same output as if it were absent.
- R9: `addr_i[j]` is compared with digit j of the stored address. Digit 0 is the rightmost, least significant position, and `load_addr_i` uses the same layout.
- R10: The folded form (FORM = FORM_FOLDED) produces the same output as the split form for every input.
- R11: `sel_o` follows `addr_i` without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the entry registers |
| rst | input | 1 | Synchronous active-high reset, clears all entries |
| order_i | input | RADIX*DW | Priority list; element k holds the digit of rank k |
| addr_i | input | NDIG*DW | Address digits; element 0 is the rightmost digit |
| load_en_i | input | 1 | Write one entry at this clock edge |
| load_idx_i | input | IW | Index of the entry to write |
| load_addr_i | input | NDIG*DW | Target address to store |
| load_data_i | input | DW | Data digit to store |
| sel_o | output | DW | Selected digit |

## Verification
An address sweep over an empty bank shows that misses return the supremum. Digit-swapped and single-digit-off addresses near a loaded target show the digit ordering and that one wrong digit rejects an entry. Reordering the priority list while the entries stay fixed shows that both the miss value and the trivial-data cases track the list. Duplicate targets holding different data show that the merge resolves by lowest rank. Long random runs, in which loads, addresses and permutations of the priority list vary together, compare both gate forms against a behavioural model on every clock.

// File: rtl/mvs_pkg.sv
package mvs_pkg;

    // Variant of the per-digit match operator.
    typedef enum logic {
        FORM_SPLIT  = 1'b0,  // match emits infimum, data enters the entry gate separately
        FORM_FOLDED = 1'b1   // match emits the data digit itself on a hit
    } match_form_e;

    // Bits needed to hold a value in 0..n-1, never less than one.
    function automatic int digit_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/mvs_digit_match.sv
module mvs_digit_match #(
    parameter  int RADIX = 4,
    localparam int DW    = mvs_pkg::digit_bits(RADIX)
) (
    input  logic [DW-1:0] digit_i,    // incoming address digit
    input  logic [DW-1:0] target_i,   // programmed digit
    input  logic [DW-1:0] hit_val_i,  // value sent on agreement
    input  logic [DW-1:0] sup_i,      // strongest digit of the entry gate
    output logic [DW-1:0] match_o
);

    always_comb begin
        if (digit_i == target_i) match_o = hit_val_i;
        else                     match_o = sup_i;
    end

endmodule

// File: rtl/mvs_prio_gate.sv
module mvs_prio_gate #(
    parameter  int RADIX = 4,
    parameter  int NIN   = 2,
    localparam int DW    = mvs_pkg::digit_bits(RADIX)
) (
    input  logic [RADIX-1:0][DW-1:0] order_i,  // element k = digit of rank k
    input  logic [NIN-1:0][DW-1:0]   ins_i,
    output logic [DW-1:0]            out_o
);

    function automatic logic [DW-1:0] rank_of(input logic [RADIX-1:0][DW-1:0] ord,
                                              input logic [DW-1:0] d);
        logic [DW-1:0] r;
        r = '0;
        for (int k = 0; k < RADIX; k++) begin
            if (ord[k] == d) r = DW'(k);
        end
        return r;
    endfunction

    logic [DW-1:0] best_rank;

    always_comb begin
        best_rank = '0;
        for (int i = 0; i < NIN; i++) begin
            if (rank_of(order_i, ins_i[i]) > best_rank) best_rank = rank_of(order_i, ins_i[i]);
        end
        out_o = order_i[best_rank];
    end

endmodule

// File: rtl/mvs_entry_bank.sv
module mvs_entry_bank #(
    parameter  int RADIX = 4,
    parameter  int NDIG  = 2,
    parameter  int NENT  = 5,
    localparam int DW    = mvs_pkg::digit_bits(RADIX),
    localparam int IW    = mvs_pkg::digit_bits(NENT)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             load_en_i,
    input  logic [IW-1:0]                    load_idx_i,
    input  logic [NDIG-1:0][DW-1:0]          load_addr_i,
    input  logic [DW-1:0]                    load_data_i,
    output logic [NENT-1:0][NDIG-1:0][DW-1:0] ent_addr_o,
    output logic [NENT-1:0][DW-1:0]          ent_data_o,
    output logic [NENT-1:0]                  ent_live_o
);

    logic [NENT-1:0][NDIG-1:0][DW-1:0] addr_q;
    logic [NENT-1:0][DW-1:0]           data_q;
    logic [NENT-1:0]                   live_q;
    logic                              idx_ok;

    assign idx_ok = int'(load_idx_i) < NENT;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
            live_q <= '0;
        end else if (load_en_i && idx_ok) begin
            addr_q[load_idx_i] <= load_addr_i;
            data_q[load_idx_i] <= load_data_i;
            live_q[load_idx_i] <= 1'b1;
        end
    end

    assign ent_addr_o = addr_q;
    assign ent_data_o = data_q;
    assign ent_live_o = live_q;

    // R2: an accepted load is stored and visible one cycle later
    assert_load_write_R2: assert property (@(posedge clk) disable iff (rst)
        (load_en_i && idx_ok) |=>
            (live_q[$past(load_idx_i)] &&
             addr_q[$past(load_idx_i)] == $past(load_addr_i) &&
             data_q[$past(load_idx_i)] == $past(load_data_i)));

    // R2: without an accepted load nothing in the bank moves
    assert_load_ignore_R2: assert property (@(posedge clk) disable iff (rst)
        (!(load_en_i && idx_ok)) |=>
            ($stable(live_q) && $stable(addr_q) && $stable(data_q)));

endmodule

// File: rtl/mvs_addr_selector.sv
module mvs_addr_selector #(
    parameter  int                  RADIX = 4,
    parameter  int                  NDIG  = 2,
    parameter  int                  NENT  = 5,
    parameter  mvs_pkg::match_form_e FORM = mvs_pkg::FORM_SPLIT,
    localparam int                  DW    = mvs_pkg::digit_bits(RADIX),
    localparam int                  IW    = mvs_pkg::digit_bits(NENT)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [RADIX-1:0][DW-1:0]  order_i,
    input  logic [NDIG-1:0][DW-1:0]   addr_i,
    input  logic                      load_en_i,
    input  logic [IW-1:0]             load_idx_i,
    input  logic [NDIG-1:0][DW-1:0]   load_addr_i,
    input  logic [DW-1:0]             load_data_i,
    output logic [DW-1:0]             sel_o
);

    localparam bit FOLDED   = (FORM == mvs_pkg::FORM_FOLDED);
    localparam int GATE_NIN = FOLDED ? NDIG : NDIG + 1;

    logic [NENT-1:0][NDIG-1:0][DW-1:0] ent_addr;
    logic [NENT-1:0][DW-1:0]           ent_data;
    logic [NENT-1:0]                   ent_live;
    logic [NENT-1:0][DW-1:0]           ent_out;
    logic [RADIX-1:0][DW-1:0]          order_m;
    logic [DW-1:0]                     sup;

    assign sup = order_i[RADIX-1];

    mvs_entry_bank #(.RADIX(RADIX), .NDIG(NDIG), .NENT(NENT)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .load_en_i  (load_en_i),
        .load_idx_i (load_idx_i),
        .load_addr_i(load_addr_i),
        .load_data_i(load_data_i),
        .ent_addr_o (ent_addr),
        .ent_data_o (ent_data),
        .ent_live_o (ent_live)
    );

    // Mirrored priority list for the merge gate.
    for (genvar k = 0; k < RADIX; k++) begin : g_mirror
        assign order_m[k] = order_i[RADIX-1-k];
    end

    for (genvar e = 0; e < NENT; e++) begin : g_entry
        logic [NDIG-1:0][DW-1:0]     mo;
        logic [GATE_NIN-1:0][DW-1:0] gin;
        logic [DW-1:0]               hit_val;
        logic [DW-1:0]               gate_out;

        if (FOLDED) begin : g_folded
            assign hit_val = ent_data[e];
            assign gin     = mo;
        end else begin : g_split
            assign hit_val = order_i[0];
            assign gin     = {ent_data[e], mo};
        end

        for (genvar j = 0; j < NDIG; j++) begin : g_dig
            mvs_digit_match #(.RADIX(RADIX)) u_match (
                .digit_i  (addr_i[j]),
                .target_i (ent_addr[e][j]),
                .hit_val_i(hit_val),
                .sup_i    (sup),
                .match_o  (mo[j])
            );
        end

        mvs_prio_gate #(.RADIX(RADIX), .NIN(GATE_NIN)) u_gate (
            .order_i(order_i),
            .ins_i  (gin),
            .out_o  (gate_out)
        );

        // An unloaded entry presents the value that the merge gate ignores.
        assign ent_out[e] = ent_live[e] ? gate_out : sup;
    end

    mvs_prio_gate #(.RADIX(RADIX), .NIN(NENT)) u_merge (
        .order_i(order_m),
        .ins_i  (ent_out),
        .out_o  (sel_o)
    );

    // ---------------- checker: independent view from stored entries ----------------
    function automatic int chk_rank(input logic [RADIX-1:0][DW-1:0] ord,
                                    input logic [DW-1:0] d);
        int r;
        r = 0;
        for (int k = 0; k < RADIX; k++) begin
            if (ord[k] == d) r = k;
        end
        return r;
    endfunction

    int            chk_hits;
    int            chk_best;
    logic          chk_m;
    logic [DW-1:0] chk_best_data;
    logic [DW-1:0] chk_last_data;

    always_comb begin
        chk_hits      = 0;
        chk_best      = RADIX;
        chk_best_data = '0;
        chk_last_data = '0;
        for (int e = 0; e < NENT; e++) begin
            chk_m = ent_live[e];
            for (int j = 0; j < NDIG; j++) begin
                if (addr_i[j] != ent_addr[e][j]) chk_m = 1'b0;
            end
            if (chk_m) begin
                chk_hits      = chk_hits + 1;
                chk_last_data = ent_data[e];
                if (chk_rank(order_i, ent_data[e]) < chk_best) begin
                    chk_best      = chk_rank(order_i, ent_data[e]);
                    chk_best_data = ent_data[e];
                end
            end
        end
    end

    // R5: nothing matches, strongest digit of the list appears
    assert_miss_sup_R5: assert property (@(posedge clk) disable iff (rst)
        (chk_hits == 0) |-> (sel_o == order_i[RADIX-1]));

    // R3: a lone match returns its own data
    assert_single_hit_R3: assert property (@(posedge clk) disable iff (rst)
        (chk_hits == 1) |-> (sel_o == chk_last_data));

    // R7: among several matches the lowest-ranked data wins
    assert_lowest_rank_R7: assert property (@(posedge clk) disable iff (rst)
        (chk_hits > 1) |-> (sel_o == chk_best_data));

endmodule

// File: tb/sim_mvs_addr_selector.sv
module sim_mvs_addr_selector;

    localparam int CLK_PERIOD = 10;
    localparam int RADIX      = 4;
    localparam int NDIG       = 2;
    localparam int NENT       = 5;
    localparam int DW         = 2;
    localparam int IW         = 3;
    localparam int NADDR      = RADIX ** NDIG;
    localparam int MAX_CYC    = 200000;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic [RADIX-1:0][DW-1:0] order;
    logic [NDIG-1:0][DW-1:0]  addr;
    logic                     ld_en;
    logic [IW-1:0]            ld_idx;
    logic [NDIG-1:0][DW-1:0]  ld_addr;
    logic [DW-1:0]            ld_data;
    logic [DW-1:0]            out_split;
    logic [DW-1:0]            out_fold;

    int    vectors  = 0;
    int    miscomp  = 0;
    bit    started  = 1'b0;
    bit    finished = 1'b0;
    string req      = "R1";

    int m_addr [NENT][NDIG];
    int m_data [NENT];
    bit m_live [NENT];

    always #(CLK_PERIOD/2) clk = ~clk;

    mvs_addr_selector #(.RADIX(RADIX), .NDIG(NDIG), .NENT(NENT),
                        .FORM(mvs_pkg::FORM_SPLIT)) u0 (
        .clk(clk), .rst(rst), .order_i(order), .addr_i(addr),
        .load_en_i(ld_en), .load_idx_i(ld_idx), .load_addr_i(ld_addr),
        .load_data_i(ld_data), .sel_o(out_split));

    mvs_addr_selector #(.RADIX(RADIX), .NDIG(NDIG), .NENT(NENT),
                        .FORM(mvs_pkg::FORM_FOLDED)) u1 (
        .clk(clk), .rst(rst), .order_i(order), .addr_i(addr),
        .load_en_i(ld_en), .load_idx_i(ld_idx), .load_addr_i(ld_addr),
        .load_data_i(ld_data), .sel_o(out_fold));

    // ---------------- behavioural reference ----------------
    function automatic int rank_of(input int d);
        for (int k = 0; k < RADIX; k++) begin
            if (int'(order[k]) == d) return k;
        end
        return 0;
    endfunction

    function automatic int model_out();
        int best;
        int bd;
        bit ok;
        best = -1;
        bd   = 0;
        for (int e = 0; e < NENT; e++) begin
            ok = m_live[e];
            for (int j = 0; j < NDIG; j++) begin
                if (m_addr[e][j] != int'(addr[j])) ok = 1'b0;
            end
            if (ok && (best < 0 || rank_of(m_data[e]) < best)) begin
                best = rank_of(m_data[e]);
                bd   = m_data[e];
            end
        end
        if (best < 0) return int'(order[RADIX-1]);
        return bd;
    endfunction

    always @(posedge clk) begin
        started = 1'b1;
        if (rst) begin
            for (int e = 0; e < NENT; e++) begin
                m_live[e] = 1'b0;
                m_data[e] = 0;
                for (int j = 0; j < NDIG; j++) m_addr[e][j] = 0;
            end
        end else if (ld_en && int'(ld_idx) < NENT) begin
            m_live[ld_idx] = 1'b1;
            m_data[ld_idx] = int'(ld_data);
            for (int j = 0; j < NDIG; j++) m_addr[ld_idx][j] = int'(ld_addr[j]);
        end
    end

    task automatic check(input string r, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            miscomp++;
            $display("FAIL %s: actual %0d expected %0d (addr=%0h order=%0h)", r, got, exp, addr, order);
        end
    endtask

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        if (started && !finished) begin
            check(req, int'(out_split), model_out());
            check("R10", int'(out_fold), model_out());
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic put_addr(input int a);
        int v;
        v = a;
        for (int j = 0; j < NDIG; j++) begin
            addr[j] = DW'(v % RADIX);
            v = v / RADIX;
        end
    endtask

    task automatic load(input int idx, input int a, input int d);
        int v;
        v = a;
        ld_en  = 1'b1;
        ld_idx = IW'(idx);
        for (int j = 0; j < NDIG; j++) begin
            ld_addr[j] = DW'(v % RADIX);
            v = v / RADIX;
        end
        ld_data = DW'(d);
        step();
        ld_en = 1'b0;
    endtask

    task automatic sweep();
        for (int a = 0; a < NADDR; a++) begin
            put_addr(a);
            step();
        end
    endtask

    task automatic set_order(input int o0, input int o1, input int o2, input int o3);
        order[0] = DW'(o0);
        order[1] = DW'(o1);
        order[2] = DW'(o2);
        order[3] = DW'(o3);
    endtask

    task automatic random_order();
        int p [RADIX];
        int t;
        int s;
        for (int k = 0; k < RADIX; k++) p[k] = k;
        for (int k = RADIX - 1; k > 0; k--) begin
            s    = int'($urandom_range(k, 0));
            t    = p[k];
            p[k] = p[s];
            p[s] = t;
        end
        for (int k = 0; k < RADIX; k++) order[k] = DW'(p[k]);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(CLK_PERIOD * MAX_CYC);
        if (!finished) begin
            finished = 1'b1;
            miscomp++;
            $display("FAIL R1: watchdog expired, actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        set_order(0, 1, 2, 3);
        addr    = '0;
        ld_en   = 1'b0;
        ld_idx  = '0;
        ld_addr = '0;
        ld_data = '0;
        repeat (2) step();
        rst = 1'b0;

        // R1: empty bank gives supremum everywhere
        req = "R1";
        sweep();

        // R9: digit order, stored address 6 means digit1=1, digit0=2
        req = "R9";
        load(0, 6, 1);
        put_addr(6);  #1; check("R9", int'(out_split), 1);
        put_addr(9);  #1; check("R9", int'(out_split), 3);
        step();

        // R4: one wrong digit rejects the entry
        req = "R4";
        put_addr(7);  #1; check("R4", int'(out_split), 3);
        put_addr(2);  #1; check("R4", int'(out_split), 3);
        step();
        sweep();

        // R3 and R8: several distinct entries, one with supremum data
        req = "R3";
        load(1, 0, 0);
        load(2, 15, 2);
        load(3, 10, 3);
        put_addr(15); #1; check("R3", int'(out_split), 2);
        put_addr(10); #1; check("R8", int'(out_split), 3);
        step();
        sweep();

        // R2: out-of-range index ignored, overwrite replaces
        req = "R2";
        load(6, 5, 0);
        put_addr(5);  #1; check("R2", int'(out_split), 3);
        step();
        load(1, 5, 2);
        put_addr(5);  #1; check("R2", int'(out_split), 2);
        put_addr(0);  #1; check("R2", int'(out_split), 3);
        step();

        // R6: new priority list, supremum becomes digit 1
        req = "R6";
        set_order(2, 0, 3, 1);
        put_addr(10); #1; check("R6", int'(out_split), 3);
        put_addr(3);  #1; check("R6", int'(out_split), 1);
        put_addr(6);  #1; check("R8", int'(out_split), 1);
        step();
        sweep();

        // R7: duplicate targets resolved by lowest rank
        req = "R7";
        set_order(0, 1, 2, 3);
        load(4, 15, 0);
        put_addr(15); #1; check("R7", int'(out_split), 0);
        set_order(2, 0, 3, 1);
        #1; check("R7", int'(out_split), 2);
        step();

        // R11: output follows the address between edges
        put_addr(5);  #1; check("R11", int'(out_split), 2);
        put_addr(3);  #1; check("R11", int'(out_split), 1);
        step();

        // R1: reset mid-run clears the bank
        req = "R1";
        rst = 1'b1;
        step();
        rst = 1'b0;
        sweep();

        // Random traffic against the model
        req = "R3";
        for (int c = 0; c < 3000; c++) begin
            if ($urandom_range(3, 0) == 0) begin
                ld_en   = 1'b1;
                ld_idx  = IW'($urandom_range(7, 0));
                ld_addr = (NDIG*DW)'($urandom);
                ld_data = DW'($urandom);
            end else begin
                ld_en = 1'b0;
            end
            if ($urandom_range(15, 0) == 0) random_order();
            addr = (NDIG*DW)'($urandom);
            step();
        end
        ld_en = 1'b0;
        step();

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end

endmodule